// File: doc/BRIEF.md
# Descending Suffix Integrator with Peak Finder

This block turns a finished histogram of single-precision bins into its suffix integral and, in the same pass, finds the largest integral value and the bin that holds it. After a start pulse it reads the bins from the highest index down to index 0 through a synchronous read port. It keeps a running floating-point sum that begins at zero and writes the sum for each bin through a write port, at that bin's own address. A floating-point comparator checks every new sum against the stored peak.

The sum is fed back straight from the adder's output register, so one bin enters the adder every adder latency (three cycles). The scan therefore takes a fixed number of cycles. A single-cycle done pulse marks the end of the scan. The peak value and its bin index then hold steady until the next start.

Top module: `rcs_suffix_max`

## Requirements
- R1: A scan reads every bin exactly once. Reads go from address NBIN-1 down to address 0, with exactly 3 cycles between consecutive reads. The first read is issued in the cycle after the start edge.
- R2: The value written for bin i equals the value of bin i plus the value written for bin i+1. The value written for bin NBIN-1 equals that bin plus +0.0. Each value is written with wr_addr equal to i, and writes go in descending address order.
- R3: Arithmetic uses IEEE-754 binary32 encoding: bit 31 is the sign, bits 30:23 are the biased exponent, and bits 22:0 are the fraction. Subnormal operands are treated as zero. A sum that is exactly representable is produced exactly, and an exact zero sum is +0.0 (32'h0000_0000).
- R4: The write for a bin occurs exactly 4 cycles after that bin's read is issued. This is one cycle of read latency plus a fixed adder latency of 3 cycles.
- R5: The peak output holds the largest written value of the scan under floating-point ordering, and negative values are ordered by magnitude with the sign taken into account. A new value replaces the peak when it is greater than or equal to the peak, so on a tie the lower bin index wins. The peak changes only in a write cycle or when a scan starts.
- R6: done is high for exactly one cycle. That cycle comes right after the write of bin 0, which is 3*NBIN+3 clock edges after the start edge (the start edge counted as the first). max_val and max_bin are valid in that cycle and stay unchanged until the next start.
- R7: A start pulse while a scan is running is ignored. The scan keeps its timing, its single done pulse and its count of NBIN reads and NBIN writes.
- R8: While reset is asserted, done, rd_en and wr_en are 0, and max_val and max_bin are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a scan when idle |
| done | output | 1 | One-cycle end-of-scan pulse |
| rd_en | output | 1 | Histogram read request |
| rd_addr | output | $clog2(NBIN) | Histogram bin address |
| rd_data | input | 32 | Bin value, valid the cycle after rd_en |
| wr_en | output | 1 | Integral write strobe |
| wr_addr | output | $clog2(NBIN) | Integral bin address |
| wr_data | output | 32 | Integral value |
| max_val | output | 32 | Largest integral seen |
| max_bin | output | $clog2(NBIN) | Bin of the largest integral |

## Verification
Each result has a fixed offset from the start edge. The read for the k-th visited bin is due at edge offset 1+3k. Its write is due 4 cycles after that read. done is due 3*NBIN+3 edges after start, and the peak outputs are due in the same cycle. The bench stamps every read and every write with a free-running cycle counter and records the edge count at which done is first seen. It compares these numbers with the offsets above, and it checks values only after the block reports completion, one cycle after the final write.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

   localparam int FP_W    = 32;
   localparam int ADD_LAT = 3;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_RUN,
      ST_DRAIN
   } scan_state_e;

   // Maps a binary32 pattern onto an unsigned key with the same ordering.
   function automatic logic [FP_W-1:0] fp_key(input logic [FP_W-1:0] x);
      return x[FP_W-1] ? ~x : (x | {1'b1, {(FP_W-1){1'b0}}});
   endfunction

   // Position of the highest set bit of a 28-bit word (0 when empty).
   function automatic logic [4:0] msb28(input logic [27:0] x);
      logic [4:0] p;
      p = '0;
      for (int i = 0; i < 28; i++) begin
         if (x[i]) p = 5'(i);
      end
      return p;
   endfunction

endpackage

// File: rtl/rcs_fp_add.sv
module rcs_fp_add
   import rcs_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_v,
   input  logic [FP_W-1:0] op_a,
   input  logic [FP_W-1:0] op_b,
   output logic            out_v,
   output logic [FP_W-1:0] sum
);

   // ---------------- stage 1: unpack, flush subnormals, order by magnitude
   logic [30:0] mag_a, mag_b;
   logic        swap;
   logic [FP_W-1:0] big, sml;

   always_comb begin
      mag_a = (op_a[30:23] == 8'd0) ? 31'd0 : op_a[30:0];
      mag_b = (op_b[30:23] == 8'd0) ? 31'd0 : op_b[30:0];
      swap  = mag_b > mag_a;
      big   = swap ? {op_b[31], mag_b} : {op_a[31], mag_a};
      sml   = swap ? {op_a[31], mag_a} : {op_b[31], mag_b};
   end

   logic        s1_v, s1_sign, s1_sub;
   logic [7:0]  s1_exp, s1_diff;
   logic [23:0] s1_mbig, s1_msml;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) s1_v <= 1'b0;
      else        s1_v <= in_v;
   end

   always_ff @(posedge clk) begin
      s1_sign <= big[31];
      s1_sub  <= big[31] ^ sml[31];
      s1_exp  <= big[30:23];
      s1_diff <= big[30:23] - sml[30:23];
      s1_mbig <= (big[30:23] == 8'd0) ? 24'd0 : {1'b1, big[22:0]};
      s1_msml <= (sml[30:23] == 8'd0) ? 24'd0 : {1'b1, sml[22:0]};
   end

   // ---------------- stage 2: align the smaller operand and add or subtract
   logic [26:0] aligned;
   logic [27:0] raw;

   always_comb begin
      aligned = (s1_diff > 8'd26) ? 27'd0 : ({s1_msml, 3'b000} >> s1_diff);
      raw     = s1_sub ? ({1'b0, s1_mbig, 3'b000} - {1'b0, aligned})
                       : ({1'b0, s1_mbig, 3'b000} + {1'b0, aligned});
   end

   logic        s2_v, s2_sign;
   logic [7:0]  s2_exp;
   logic [27:0] s2_sum;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) s2_v <= 1'b0;
      else        s2_v <= s1_v;
   end

   always_ff @(posedge clk) begin
      s2_sign <= s1_sign;
      s2_exp  <= s1_exp;
      s2_sum  <= raw;
   end

   // ---------------- stage 3: normalise, truncate, pack
   logic [4:0]        lead;
   logic [27:0]       norm;
   logic signed [9:0] exp_new;
   logic [FP_W-1:0]   packed_res;

   always_comb begin
      lead    = msb28(s2_sum);
      norm    = (lead == 5'd27) ? (s2_sum >> 1) : (s2_sum << (5'd26 - lead));
      exp_new = $signed({2'b00, s2_exp}) + $signed({5'b00000, lead}) - 10'sd26;
      if (s2_sum == 28'd0 || exp_new <= 10'sd0) packed_res = '0;
      else if (exp_new >= 10'sd255)             packed_res = {s2_sign, 8'hFF, 23'd0};
      else                                      packed_res = {s2_sign, exp_new[7:0], norm[25:3]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_v <= 1'b0;
      else        out_v <= s2_v;
   end

   always_ff @(posedge clk) sum <= packed_res;

   assert_add_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
      in_v |-> ##3 out_v);

endmodule

// File: rtl/rcs_fp_ge.sv
module rcs_fp_ge
   import rcs_pkg::*;
(
   input  logic [FP_W-1:0] lhs,
   input  logic [FP_W-1:0] rhs,
   output logic            ge
);

   assign ge = fp_key(lhs) >= fp_key(rhs);

endmodule

// File: rtl/rcs_max_track.sv
module rcs_max_track
   import rcs_pkg::*;
#(
   parameter int AW           = 8,
   parameter bit TIE_LOW_WINS = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear,
   input  logic            upd,
   input  logic [FP_W-1:0] val,
   input  logic [AW-1:0]   bin,
   output logic [FP_W-1:0] max_val,
   output logic [AW-1:0]   max_bin
);

   logic have_q;
   logic cmp_ge;
   logic better;

   // Later visits carry lower bins: ">=" hands ties to the lower bin,
   // strict ">" keeps the higher one.
   generate
      if (TIE_LOW_WINS) begin : g_tie_low
         rcs_fp_ge u_cmp (.lhs(val), .rhs(max_val), .ge(cmp_ge));
         assign better = cmp_ge;
      end else begin : g_tie_high
         rcs_fp_ge u_cmp (.lhs(max_val), .rhs(val), .ge(cmp_ge));
         assign better = !cmp_ge;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_q  <= 1'b0;
         max_val <= '0;
         max_bin <= '0;
      end else if (clear) begin
         have_q  <= 1'b0;
      end else if (upd && (!have_q || better)) begin
         have_q  <= 1'b1;
         max_val <= val;
         max_bin <= bin;
      end
   end

   assert_max_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(clear || upd) |=> ($stable(max_val) && $stable(max_bin)));

endmodule

// File: rtl/rcs_suffix_max.sv
module rcs_suffix_max
   import rcs_pkg::*;
#(
   parameter  int NBIN         = 256,
   parameter  bit TIE_LOW_WINS = 1'b1,
   localparam int AW           = $clog2(NBIN)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   output logic            done,
   output logic            rd_en,
   output logic [AW-1:0]   rd_addr,
   input  logic [FP_W-1:0] rd_data,
   output logic            wr_en,
   output logic [AW-1:0]   wr_addr,
   output logic [FP_W-1:0] wr_data,
   output logic [FP_W-1:0] max_val,
   output logic [AW-1:0]   max_bin
);

   localparam logic [1:0] PH_READ = 2'd0;
   localparam logic [1:0] PH_ADD  = 2'd1;
   localparam logic [1:0] PH_LAST = 2'(ADD_LAT - 1);

   generate
      if (NBIN < 2) begin : g_bad_nbin
         $error("rcs_suffix_max: NBIN must be at least 2");
      end
      if (ADD_LAT != 3) begin : g_bad_lat
         $error("rcs_suffix_max: phase counter sized for an adder latency of 3");
      end
   endgenerate

   scan_state_e     state_q;
   logic [1:0]      phase_q;
   logic [AW-1:0]   bin_q, wbin_q;
   logic            first_q, done_q;
   logic            accept;
   logic            add_in_v, add_out_v;
   logic [FP_W-1:0] add_b, add_sum;

   assign accept = (state_q == ST_IDLE) && start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         phase_q <= PH_READ;
         bin_q   <= '0;
         wbin_q  <= '0;
         first_q <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  state_q <= ST_RUN;
                  phase_q <= PH_READ;
                  bin_q   <= AW'(NBIN - 1);
                  wbin_q  <= AW'(NBIN - 1);
                  first_q <= 1'b1;
               end
            end
            ST_RUN: begin
               phase_q <= (phase_q == PH_LAST) ? PH_READ : phase_q + 2'd1;
               if (phase_q == PH_ADD) first_q <= 1'b0;
               if (phase_q == PH_LAST) begin
                  if (bin_q == '0) state_q <= ST_DRAIN;
                  else             bin_q   <= bin_q - 1'b1;
               end
            end
            ST_DRAIN: begin
               if (add_out_v && wbin_q == '0) begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
         if (add_out_v && state_q != ST_IDLE) wbin_q <= wbin_q - 1'b1;
      end
   end

   assign rd_en    = (state_q == ST_RUN) && (phase_q == PH_READ);
   assign rd_addr  = bin_q;
   assign add_in_v = (state_q == ST_RUN) && (phase_q == PH_ADD);
   // Forward the previous integral straight from the adder output register.
   assign add_b    = first_q ? '0 : add_sum;

   rcs_fp_add u_add (
      .clk   (clk),
      .rst_n (rst_n),
      .in_v  (add_in_v),
      .op_a  (rd_data),
      .op_b  (add_b),
      .out_v (add_out_v),
      .sum   (add_sum)
   );

   assign wr_en   = add_out_v;
   assign wr_addr = wbin_q;
   assign wr_data = add_sum;
   assign done    = done_q;

   rcs_max_track #(.AW(AW), .TIE_LOW_WINS(TIE_LOW_WINS)) u_max (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (accept),
      .upd     (add_out_v),
      .val     (add_sum),
      .bin     (wbin_q),
      .max_val (max_val),
      .max_bin (max_bin)
   );

   assert_read_descend_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr != '0) |-> ##3 (rd_en && rd_addr == $past(rd_addr, 3) - 1'b1));

   assert_read_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> !rd_en);

   assert_write_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> ##4 (wr_en && wr_addr == $past(rd_addr, 4)));

   assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_after_bin0_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> ($past(wr_en) && $past(wr_addr) == '0));

endmodule

// File: tb/test_rcs_suffix_max.sv
module test_rcs_suffix_max;

   localparam int N  = 16;
   localparam int AW = $clog2(N);
   localparam int NV = 8;
   // kind, p, q : value generator selectors
   localparam int VEC [NV][3] = '{
      '{0, 1, 0}, '{1, 1, 0}, '{2, 3, 2}, '{3, 10, 1},
      '{4, 2, 0}, '{5, 7, 5}, '{6, 3, 0}, '{7, 1, 0}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          done, rd_en, wr_en;
   logic [AW-1:0] rd_addr, wr_addr, max_bin;
   logic [31:0]   rd_data = '0;
   logic [31:0]   wr_data, max_val;

   always #4 clk = ~clk;

   rcs_suffix_max #(.NBIN(N)) i_rcs_suffix_max (
      .clk(clk), .rst_n(rst_n), .start(start), .done(done),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .max_val(max_val), .max_bin(max_bin)
   );

   int          checks = 0, fails = 0;
   int          cyc = 0, rcount = 0, wcount = 0, dcount = 0;
   logic [31:0] hist_mem [N];
   int          hv [N];
   logic [31:0] exp_w [N];
   logic [31:0] exp_max;
   int          exp_bin;
   int          rd_a [1024], rd_c [1024], wr_a [1024], wr_c [1024];
   logic [31:0] wr_d [1024];

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (rd_en) begin
         rd_data <= hist_mem[rd_addr];
         if (rcount < 1024) begin
            rd_a[rcount] <= int'(rd_addr);
            rd_c[rcount] <= cyc;
         end
         rcount <= rcount + 1;
      end
      if (wr_en) begin
         if (wcount < 1024) begin
            wr_a[wcount] <= int'(wr_addr);
            wr_c[wcount] <= cyc;
            wr_d[wcount] <= wr_data;
         end
         wcount <= wcount + 1;
      end
      if (done) dcount <= dcount + 1;
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
      end
   endtask

   function automatic logic [31:0] int2fp(input int v);
      int          a, m;
      logic [31:0] sh;
      if (v == 0) return 32'h0;
      a = (v < 0) ? -v : v;
      m = 0;
      for (int i = 0; i < 24; i++) if (a[i]) m = i;
      sh = 32'(a) << (23 - m);
      return {(v < 0), 8'(127 + m), sh[22:0]};
   endfunction

   function automatic int gen(input int kind, input int p, input int q, input int i);
      case (kind)
         0: return p;
         1: return i + p;
         2: return (i < N / 2) ? -p : q;
         3: return (i >= p) ? q : 0;
         4: return -p;
         5: return ((i * p) % 11) - q;
         6: return (i % 2 == 1) ? (1 << 20) : p;
         default: return (i == N - 1) ? (1 << 22) : (i == N - 2) ? -(1 << 22) : p;
      endcase
   endfunction

   // Suffix integrals and peak (ties to the lower bin) from integer values.
   task automatic compute_expected();
      int acc, best;
      acc = 0;
      best = 0;
      for (int i = N - 1; i >= 0; i--) begin
         acc = acc + hv[i];
         exp_w[i] = int2fp(acc);
         if (i == N - 1 || acc >= best) begin
            best = acc;
            exp_bin = i;
         end
      end
      exp_max = int2fp(best);
   endtask

   task automatic run_scan(input bit restart_mid, input string tag);
      int r0, w0, d0, edges;
      r0 = rcount; w0 = wcount; d0 = dcount;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      edges = 1;
      while (!done && edges < 5000) begin
         start = (restart_mid && edges == 10);
         @(negedge clk);
         edges++;
      end
      start = 1'b0;
      check(edges == 3 * N + 3, "R6", {tag, " done edge"}, 32'(edges), 32'(3 * N + 3));
      check(rcount - r0 == N, "R1", {tag, " read count"}, 32'(rcount - r0), 32'(N));
      check(wcount - w0 == N, "R2", {tag, " write count"}, 32'(wcount - w0), 32'(N));
      for (int k = 0; k < N; k++) begin
         check(rd_a[r0 + k] == N - 1 - k, "R1", {tag, " read addr"},
               32'(rd_a[r0 + k]), 32'(N - 1 - k));
         if (k > 0)
            check(rd_c[r0 + k] - rd_c[r0 + k - 1] == 3, "R1", {tag, " read spacing"},
                  32'(rd_c[r0 + k] - rd_c[r0 + k - 1]), 32'd3);
         check(wr_a[w0 + k] == N - 1 - k, "R2", {tag, " write addr"},
               32'(wr_a[w0 + k]), 32'(N - 1 - k));
         check(wr_c[w0 + k] - rd_c[r0 + k] == 4, "R4", {tag, " read-to-write"},
               32'(wr_c[w0 + k] - rd_c[r0 + k]), 32'd4);
         check(wr_d[w0 + k] == exp_w[N - 1 - k], "R2", {tag, " integral"},
               wr_d[w0 + k], exp_w[N - 1 - k]);
      end
      check(max_val == exp_max, "R5", {tag, " peak value"}, max_val, exp_max);
      check(int'(max_bin) == exp_bin, "R5", {tag, " peak bin"}, 32'(max_bin), 32'(exp_bin));
      repeat (4) @(negedge clk);
      check(dcount - d0 == 1, "R6", {tag, " done pulses"}, 32'(dcount - d0), 32'd1);
      check(max_val == exp_max && int'(max_bin) == exp_bin, "R6", {tag, " peak held"},
            max_val, exp_max);
   endtask

   initial begin
      #(8 * 150000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R8: outputs while held in reset
      check(!done && !rd_en && !wr_en, "R8", "reset strobes",
            {29'd0, done, rd_en, wr_en}, 32'd0);
      check(max_val == 0 && max_bin == 0, "R8", "reset peak", max_val, 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(!rd_en && !wr_en, "R8", "idle after reset", {30'd0, rd_en, wr_en}, 32'd0);

      // Table of value patterns: R1, R2, R4, R5, R6 (negatives exercise R5 ordering)
      for (int v = 0; v < NV; v++) begin
         for (int i = 0; i < N; i++) begin
            hv[i] = gen(VEC[v][0], VEC[v][1], VEC[v][2], i);
            hist_mem[i] = int2fp(hv[i]);
         end
         compute_expected();
         run_scan(1'b0, $sformatf("vec%0d", v));
      end

      // R7: a second start during the scan is ignored
      for (int i = 0; i < N; i++) begin
         hv[i] = i % 3;
         hist_mem[i] = int2fp(hv[i]);
      end
      compute_expected();
      run_scan(1'b1, "restart");

      // R3: subnormal operand counts as zero, exact zero gives +0.0
      for (int i = 0; i < N; i++) begin
         hv[i] = 0;
         hist_mem[i] = 32'h0;
      end
      hist_mem[N - 1] = 32'h0000_0001;
      hv[N - 2] = 5;
      hist_mem[N - 2] = int2fp(5);
      hv[N - 3] = -5;
      hist_mem[N - 3] = int2fp(-5);
      compute_expected();
      run_scan(1'b0, "subnormal");
      check(wr_d[wcount - N] == 32'h0, "R3", "subnormal flushed", wr_d[wcount - N], 32'h0);
      check(wr_d[wcount - N + 2] == 32'h0, "R3", "cancel to +0", wr_d[wcount - N + 2], 32'h0);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule